// File: doc/BRIEF.md
# Precise Exception Tracker for a Five-Stage Pipeline

This block runs beside a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It holds its own copy of the pipeline latches, and each latch carries a valid bit, the instruction's PC and a per-instruction fault vector. Each stage can raise fault indications for the instruction it currently holds. Those indications are ORed into that instruction's vector and travel with it. Faults are never acted on where they appear. Only when an instruction reaches writeback is its vector examined. Faults that arrive out of order in time are therefore resolved in program order.

While an instruction carries any fault, the block withholds its register-file write and its store. When a faulting instruction reaches writeback, the block pulses `take_trap` and reports a cause code and the faulting PC. It also flushes every younger stage that holds an instruction. One cycle later it raises `trap_fetch`, so the datapath inserts the trap instruction at fetch. An external interrupt request is joined to the instruction in decode, and only while interrupts are enabled. In this way the interrupt is taken between instructions.

The pipeline advances one stage per clock. A bubble is an entry with its valid bit low.

Top module: `exc_tracker`

## Requirements
- R1: Fault indications are taken only for a valid instruction in the stage that raises them. They are kept with that instruction until writeback. Fetch faults use `if_flt` and data faults use `mem_flt`, with the same field layout: bit 0 page fault, bit 1 misaligned, bit 2 protection.
- R2: `rf_we` is high exactly when `wb_wr` is high, the writeback entry is valid, and that entry carries no fault.
- R3: `mem_we` is low whenever any of these holds: the memory-stage entry already carries a fault, `mem_flt` is non-zero, or a trap is being taken in the same cycle. Otherwise it is high exactly when `mem_st` is high and the memory-stage entry is valid.
- R4: `take_trap` is high exactly while the writeback entry is valid and carries a fault. The oldest faulting instruction is therefore always reported first, even when a younger one raised its fault earlier in time.
- R5: `cause` reports the first set fault in this order: fetch page fault, fetch misaligned, fetch protection, interrupt, undefined opcode, overflow, data page fault, data misaligned, data protection. The codes are: 1 page fault, 2 misaligned, 3 protection, 4 undefined opcode, 5 overflow, 6 interrupt. `cause_data` is 1 only for the three data faults. While no trap is taken, both are 0.
- R6: While a trap is taken, `flush` has bit 0 (fetch), bit 1 (decode), bit 2 (execute) and bit 3 (memory) set for each stage that holds a valid instruction. In the next cycle all those instructions are gone: there is no trap and no `rf_we`. Otherwise `flush` is 0.
- R7: `trap_fetch` is high in exactly the cycle after each `take_trap` cycle.
- R8: When `irq_req` and `irq_en` are both high, the valid decode-stage instruction carries an interrupt fault. With `irq_en` low, the request leaves no trace.
- R9: While a trap is taken, `epc` equals the PC with which the faulting instruction was fetched.
- R10: After reset the pipeline is empty, and `take_trap`, `trap_fetch`, `flush`, `rf_we` and `mem_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_valid | input | 1 | Fetch stage holds an instruction |
| if_pc | input | PC_W | PC of the fetched instruction |
| if_flt | input | 3 | Fetch faults: page, misaligned, protection |
| id_undef | input | 1 | Decode found an undefined opcode |
| ex_ovf | input | 1 | Execute raised arithmetic overflow |
| mem_flt | input | 3 | Data access faults: page, misaligned, protection |
| irq_req | input | 1 | External interrupt request |
| irq_en | input | 1 | Interrupts unmasked |
| mem_st | input | 1 | Memory-stage instruction wants to store |
| wb_wr | input | 1 | Writeback instruction wants to write a register |
| rf_we | output | 1 | Permitted register-file write |
| mem_we | output | 1 | Permitted store |
| take_trap | output | 1 | Exception taken this cycle |
| flush | output | 4 | Younger stages turned into bubbles |
| trap_fetch | output | 1 | Insert trap instruction at fetch |
| cause | output | 3 | Cause code of the taken exception |
| cause_data | output | 1 | Cause came from a data access |
| epc | output | PC_W | PC of the faulting instruction |

## Verification
Random traffic with sparse faults in every stage stresses trap timing against bubbles, stores and register writes. Several directed patterns separate program order from time order. In one, an older instruction faults in memory after a younger one has already faulted at fetch; only the older instruction may be reported. Another pattern gives one instruction both a fetch fault and an overflow, and a third gives one instruction both an undefined opcode and an overflow; these show that the fault priority is honoured. Paired runs with the interrupt masked and then unmasked show that enabling alone decides whether a request becomes a trap.

// File: rtl/exc_tracker.sv
module exc_tracker #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            if_valid,
  input  logic [PC_W-1:0] if_pc,
  input  logic [2:0]      if_flt,
  input  logic            id_undef,
  input  logic            ex_ovf,
  input  logic [2:0]      mem_flt,
  input  logic            irq_req,
  input  logic            irq_en,
  input  logic            mem_st,
  input  logic            wb_wr,
  output logic            rf_we,
  output logic            mem_we,
  output logic            take_trap,
  output logic [3:0]      flush,
  output logic            trap_fetch,
  output logic [2:0]      cause,
  output logic            cause_data,
  output logic [PC_W-1:0] epc
);
  localparam int VW = 9;
  localparam int NS = 4;
  localparam int SW = $clog2(VW + 1);

  logic [NS-1:0]   v;
  logic [VW-1:0]   vec [NS];
  logic [PC_W-1:0] pc  [NS];

  logic [VW-1:0] post_id, post_ex, post_mem;
  logic [SW-1:0] sel;
  logic [2:0]    code;

  assign post_id  = {4'b0, id_undef, irq_req & irq_en, 3'b0};
  assign post_ex  = {3'b0, ex_ovf, 5'b0};
  assign post_mem = {mem_flt, 6'b0};

  assign take_trap = v[3] & (|vec[3]);
  assign flush     = {4{take_trap}} & {v[2], v[1], v[0], if_valid};
  assign rf_we     = wb_wr & v[3] & ~(|vec[3]);
  assign mem_we    = mem_st & v[2] & ~(|vec[2]) & ~(|mem_flt) & ~take_trap;
  assign epc       = pc[3];

  always_ff @(posedge clk) begin
    if (!rst_n || take_trap) begin
      for (int i = 0; i < NS; i++) begin
        v[i]   <= 1'b0;
        vec[i] <= '0;
        pc[i]  <= '0;
      end
    end else begin
      v[0]   <= if_valid;
      vec[0] <= if_valid ? {6'b0, if_flt} : '0;
      pc[0]  <= if_pc;
      v[1]   <= v[0];
      vec[1] <= v[0] ? (vec[0] | post_id) : '0;
      pc[1]  <= pc[0];
      v[2]   <= v[1];
      vec[2] <= v[1] ? (vec[1] | post_ex) : '0;
      pc[2]  <= pc[1];
      v[3]   <= v[2];
      vec[3] <= v[2] ? (vec[2] | post_mem) : '0;
      pc[3]  <= pc[2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) trap_fetch <= 1'b0;
    else        trap_fetch <= take_trap;
  end

  always_comb begin
    sel = SW'(VW);
    for (int i = VW - 1; i >= 0; i--)
      if (vec[3][i]) sel = SW'(i);
  end

  always_comb begin
    case (sel)
      SW'(0), SW'(6): code = 3'd1;
      SW'(1), SW'(7): code = 3'd2;
      SW'(2), SW'(8): code = 3'd3;
      SW'(3):         code = 3'd6;
      SW'(4):         code = 3'd4;
      SW'(5):         code = 3'd5;
      default:        code = 3'd0;
    endcase
  end

  assign cause      = take_trap ? code : 3'd0;
  assign cause_data = take_trap & (sel >= SW'(6)) & (sel < SW'(VW));
endmodule

// File: rtl/exc_tracker_chk.sv
module exc_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       take_trap,
  input logic       trap_fetch,
  input logic       rf_we,
  input logic       mem_we,
  input logic       mem_st,
  input logic [2:0] mem_flt,
  input logic [2:0] cause
);
  assert_trap_blocks_rf_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap |-> !rf_we);

  assert_trap_blocks_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap |-> !mem_we);

  assert_faulted_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_st && mem_flt != 3'b000) |-> !mem_we);

  assert_cause_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap |-> (cause != 3'd0 && cause != 3'd7));

  assert_flushed_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap |=> (!take_trap && !rf_we));

  assert_trap_fetch_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap |=> trap_fetch);
endmodule

bind exc_tracker exc_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .take_trap(take_trap), .trap_fetch(trap_fetch),
  .rf_we(rf_we), .mem_we(mem_we), .mem_st(mem_st), .mem_flt(mem_flt), .cause(cause)
);

// File: tb/exc_tracker_bench.sv
`timescale 1ns/1ps
module exc_tracker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        if_valid = 1'b0;
  logic [31:0] if_pc = '0;
  logic [2:0]  if_flt = '0;
  logic        id_undef = 1'b0, ex_ovf = 1'b0;
  logic [2:0]  mem_flt = '0;
  logic        irq_req = 1'b0, irq_en = 1'b0, mem_st = 1'b0, wb_wr = 1'b0;
  logic        rf_we, mem_we, take_trap, trap_fetch, cause_data;
  logic [3:0]  flush;
  logic [2:0]  cause;
  logic [31:0] epc;

  int errors = 0;
  int checks = 0;

  exc_tracker #(.PC_W(32)) u_exc_tracker (
    .clk(clk), .rst_n(rst_n), .if_valid(if_valid), .if_pc(if_pc), .if_flt(if_flt),
    .id_undef(id_undef), .ex_ovf(ex_ovf), .mem_flt(mem_flt), .irq_req(irq_req),
    .irq_en(irq_en), .mem_st(mem_st), .wb_wr(wb_wr), .rf_we(rf_we), .mem_we(mem_we),
    .take_trap(take_trap), .flush(flush), .trap_fetch(trap_fetch), .cause(cause),
    .cause_data(cause_data), .epc(epc)
  );

  always #2 clk = ~clk;

  bit          mv  [4];
  logic [8:0]  mvec[4];
  logic [31:0] mpc [4];
  bit          mprev;

  function automatic logic [3:0] exp_cause(input logic [8:0] fv);
    logic [3:0] r;
    r = 4'd0;
    for (int i = 8; i >= 0; i--)
      if (fv[i]) begin
        case (i)
          0, 6: r = 4'd1;
          1, 7: r = 4'd2;
          2, 8: r = 4'd3;
          3:    r = 4'd6;
          4:    r = 4'd4;
          default: r = 4'd5;
        endcase
        r[3] = (i >= 6);
      end
    return r;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit iv, input logic [31:0] p, input logic [2:0] ifl,
                      input bit und, input bit ovf, input logic [2:0] mf,
                      input bit irq, input bit ien, input bit st, input bit wr);
    bit tk;
    logic [3:0] ec;
    if_valid = iv; if_pc = p; if_flt = ifl; id_undef = und; ex_ovf = ovf;
    mem_flt = mf; irq_req = irq; irq_en = ien; mem_st = st; wb_wr = wr;
    #1;
    tk = mv[3] && (mvec[3] != 0);
    ec = exp_cause(mvec[3]);
    chk(32'(take_trap), 32'(tk), "R4 take_trap");
    chk(32'(cause), tk ? 32'(ec[2:0]) : 0, "R5 cause");
    chk(32'(cause_data), tk ? 32'(ec[3]) : 0, "R5 cause_data");
    if (tk) chk(epc, mpc[3], "R9 epc");
    chk(32'(flush), tk ? 32'({mv[2], mv[1], mv[0], iv}) : 0, "R6 flush");
    chk(32'(rf_we), 32'(wr && mv[3] && mvec[3] == 0), "R2 rf_we");
    chk(32'(mem_we), 32'(st && mv[2] && mvec[2] == 0 && mf == 0 && !tk), "R3 mem_we");
    chk(32'(trap_fetch), 32'(mprev), "R7 trap_fetch");
    @(posedge clk);
    mprev = tk;
    if (tk) begin
      for (int i = 0; i < 4; i++) begin mv[i] = 0; mvec[i] = '0; end
    end else begin
      mv[3] = mv[2]; mpc[3] = mpc[2];
      mvec[3] = mv[2] ? (mvec[2] | {mf, 6'b0}) : '0;
      mv[2] = mv[1]; mpc[2] = mpc[1];
      mvec[2] = mv[1] ? (mvec[1] | {3'b0, ovf, 5'b0}) : '0;
      mv[1] = mv[0]; mpc[1] = mpc[0];
      mvec[1] = mv[0] ? (mvec[0] | {4'b0, und, irq && ien, 3'b0}) : '0;
      mv[0] = iv; mpc[0] = p;
      mvec[0] = iv ? {6'b0, ifl} : '0;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic peek(input bit et, input logic [2:0] ec, input bit ed,
                      input logic [31:0] ep, input string tag);
    chk(32'(take_trap), 32'(et), {tag, " peek take_trap"});
    if (et) begin
      chk(32'(cause), 32'(ec), {tag, " peek cause"});
      chk(32'(cause_data), 32'(ed), {tag, " peek cause_data"});
      chk(epc, ep, {tag, " peek epc"});
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] pcv;
    for (int i = 0; i < 4; i++) begin mv[i] = 0; mvec[i] = '0; mpc[i] = '0; end
    mprev = 0;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10: reset state
    chk(32'(take_trap), 0, "R10 take_trap");
    chk(32'(trap_fetch), 0, "R10 trap_fetch");
    chk(32'(flush), 0, "R10 flush");
    chk(32'(rf_we), 0, "R10 rf_we");
    chk(32'(mem_we), 0, "R10 mem_we");
    @(negedge clk);

    // R4: older memory fault wins over a younger, earlier fetch fault
    step(1, 32'h100, 0, 0, 0, 0, 0, 0, 0, 1);
    step(1, 32'h104, 3'b001, 0, 0, 0, 0, 0, 0, 1);
    step(1, 32'h108, 0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 3'b010, 0, 0, 1, 1);
    peek(1, 3'd2, 1, 32'h100, "R4");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    peek(0, 0, 0, 0, "R6");
    chk(32'(trap_fetch), 1, "R7 after trap");
    idle(5);

    // R1: fetch protection fault carried to writeback
    step(1, 32'h200, 3'b100, 0, 0, 0, 0, 0, 0, 0);
    idle(3);
    peek(1, 3'd3, 0, 32'h200, "R1");
    idle(5);
    // R1: data protection fault
    step(1, 32'h204, 0, 0, 0, 0, 0, 0, 0, 0);
    idle(2);
    step(0, 0, 0, 0, 0, 3'b100, 0, 0, 0, 0);
    peek(1, 3'd3, 1, 32'h204, "R1");
    idle(5);

    // R5: fetch misaligned beats overflow in the same instruction
    step(1, 32'h300, 3'b010, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    peek(1, 3'd2, 0, 32'h300, "R5");
    idle(5);
    // R5: undefined opcode beats overflow
    step(1, 32'h304, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    peek(1, 3'd4, 0, 32'h304, "R5");
    idle(5);

    // R8: masked interrupt leaves no trace, unmasked one traps with cause 6
    step(1, 32'h400, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    idle(2);
    peek(0, 0, 0, 0, "R8 masked");
    idle(5);
    step(1, 32'h404, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 1, 0, 0);
    idle(2);
    peek(1, 3'd6, 0, 32'h404, "R8 unmasked");
    idle(5);

    // Random traffic, all outputs checked against the bench model every cycle
    pcv = 32'h1000;
    for (int n = 0; n < 3000; n++) begin
      bit iv;
      logic [2:0] ifl, mf;
      iv  = ($urandom % 4) != 0;
      ifl = (($urandom % 14) == 0) ? 3'($urandom % 7 + 1) : 3'b000;
      mf  = (($urandom % 14) == 0) ? 3'($urandom % 7 + 1) : 3'b000;
      step(iv, pcv, ifl, ($urandom % 16) == 0, ($urandom % 16) == 0, mf,
           ($urandom % 10) == 0, ($urandom % 2) == 0, ($urandom % 2) == 0,
           ($urandom % 3) != 0);
      if (iv) pcv = pcv + 4;
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule